// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a single-stage vector integer execution unit. It accepts two 128-bit source vectors, an already-decoded operation code and a lane-size code. It splits both sources into independent lanes of 8, 16 or 32 bits and applies the same operation to every lane pair. Lane i of the result depends only on lane i of each source. Carries, comparisons, shifts and rotates never cross a lane boundary.

The combinational result is captured in one output register, together with a valid flag, on the clock edge after the inputs are presented. The lane width is chosen on each cycle, so consecutive operations may use different views of the same 128-bit word. There is no handshake: when `in_valid` is high the operation is accepted, and the result appears one cycle later.

Top module: `simd_int_alu`

## Requirements
- R1: `in_size` selects the lane width: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes, 2 gives four 32-bit lanes, and 3 behaves exactly like 2.
- R2: Opcode 0 (add) gives each lane (a+b) modulo 2^width, and the carry out of one lane never reaches the next lane.
- R3: Opcode 1 gives the unsigned minimum of each lane pair, and opcode 2 gives the signed (two's complement) minimum.
- R4: Opcode 3 gives the unsigned rounding average (a+b+1)>>1 per lane, computed with one extra bit so that it never overflows.
- R5: Opcodes 4, 5 and 6 give the bitwise AND, OR and XOR of the two sources.
- R6: Opcode 7 (equal), opcode 8 (unsigned greater-than, a>b) and opcode 9 (signed greater-than) write all ones to a lane when the condition holds and all zeros when it does not.
- R7: Opcodes 10 (shift left), 11 (logical shift right), 12 (arithmetic shift right) and 13 (rotate left) shift lane i of A by the low log2(width) bits of lane i of B.
- R8: The result and `out_valid` appear on the clock edge after `in_valid` is sampled high. When `in_valid` is low, `out_valid` is low on the next cycle and `out_result` holds its previous value.
- R9: While synchronous reset is high, `out_valid` and `out_result` are cleared to zero.
- R10: The unused opcodes 14 and 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Decoded operation code |
| in_size | input | 2 | Lane-width code |
| in_a | input | 128 | Source vector A |
| in_b | input | 128 | Source vector B |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 128 | Registered result vector |

## Verification
The hardest case to reach is a leak across a lane boundary. It only appears when a lane produces a carry, a sign bit or shifted-out bits next to a neighbouring lane whose expected value would visibly change. The stimulus therefore uses all-ones lanes added to one, sign-boundary values, and shift counts whose upper bits are set, so that truncating the count matters. Each of these patterns is replayed under every lane-size code, so that a fault tied to one lane width shows up.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_MINU  = 4'd1,
    OP_MINS  = 4'd2,
    OP_AVGU  = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_CMPEQ = 4'd7,
    OP_CMPGU = 4'd8,
    OP_CMPGS = 4'd9,
    OP_SHL   = 4'd10,
    OP_SHRL  = 4'd11,
    OP_SHRA  = 4'd12,
    OP_ROTL  = 4'd13,
    OP_RSV0  = 4'd14,
    OP_RSV1  = 4'd15
  } opcode_e;

  localparam int NUM_WIDTHS = 3;
  localparam int BASE_WIDTH = 8;
endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op #(
  parameter int W = 8
) (
  input  simd_pkg::opcode_e op,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [W-1:0]      res
);
  import simd_pkg::*;

  localparam int SW = $clog2(W);

  logic [SW-1:0]  sh;
  logic [W:0]     avg_sum;
  logic [2*W-1:0] rot_tmp;

  assign sh      = b[SW-1:0];
  assign avg_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
  assign rot_tmp = {a, a} << sh;

  always_comb begin
    case (op)
      OP_ADD:   res = a + b;
      OP_MINU:  res = (a < b) ? a : b;
      OP_MINS:  res = ($signed(a) < $signed(b)) ? a : b;
      OP_AVGU:  res = avg_sum[W:1];
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_CMPEQ: res = (a == b) ? {W{1'b1}} : {W{1'b0}};
      OP_CMPGU: res = (a > b) ? {W{1'b1}} : {W{1'b0}};
      OP_CMPGS: res = ($signed(a) > $signed(b)) ? {W{1'b1}} : {W{1'b0}};
      OP_SHL:   res = a << sh;
      OP_SHRL:  res = a >> sh;
      OP_SHRA:  res = W'($signed(a) >>> sh);
      OP_ROTL:  res = rot_tmp[2*W-1:W];
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/simd_width_bank.sv
module simd_width_bank #(
  parameter int VEC = 128,
  parameter int W   = 8
) (
  input  simd_pkg::opcode_e op,
  input  logic [VEC-1:0]    a,
  input  logic [VEC-1:0]    b,
  output logic [VEC-1:0]    res
);
  localparam int LANES = VEC / W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    simd_lane_op #(.W(W)) u_lane (
      .op  (op),
      .a   (a[i*W +: W]),
      .b   (b[i*W +: W]),
      .res (res[i*W +: W])
    );
  end
endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu #(
  parameter int VEC = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       in_op,
  input  logic [1:0]       in_size,
  input  logic [VEC-1:0]   in_a,
  input  logic [VEC-1:0]   in_b,
  output logic             out_valid,
  output logic [VEC-1:0]   out_result
);
  import simd_pkg::*;

  logic [VEC-1:0] bank_res [NUM_WIDTHS];
  logic [VEC-1:0] sel_res;
  opcode_e        op_e;

  assign op_e = opcode_e'(in_op);

  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_bank
    simd_width_bank #(.VEC(VEC), .W(BASE_WIDTH << k)) u_bank (
      .op  (op_e),
      .a   (in_a),
      .b   (in_b),
      .res (bank_res[k])
    );
  end

  always_comb begin
    case (in_size)
      2'd0:    sel_res = bank_res[0];
      2'd1:    sel_res = bank_res[1];
      default: sel_res = bank_res[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= sel_res;
    end
  end

  function automatic logic lanes_uniform(logic [VEC-1:0] v, logic [1:0] sz);
    int w;
    logic ok;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    ok = 1'b1;
    for (int j = 0; j < VEC; j++)
      if (v[j] != v[(j / w) * w]) ok = 1'b0;
    return ok;
  endfunction

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0)); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op >= 4'd14) |=> out_result == '0); // R10
  AST_CMP_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op >= 4'd7 && in_op <= 4'd9) |=> lanes_uniform(out_result, $past(in_size))); // R6
  AST_BYTE_ADD_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd0 && in_size == 2'd0) |=>
      out_result[15:8] == 8'($past(in_a[15:8]) + $past(in_b[15:8]))); // R2
endmodule

// File: tb/sim_simd_int_alu.sv
module sim_simd_int_alu;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [3:0]   in_op;
  logic [1:0]   in_size;
  logic [127:0] in_a, in_b;
  logic         out_valid;
  logic [127:0] out_result;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  simd_int_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [31:0] ref_lane(int op, int w, logic [31:0] a, logic [31:0] b);
    longint mask, ua, ub, sa, sb, half, r;
    int sh;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    ua = longint'(a) & mask;
    ub = longint'(b) & mask;
    sa = (ua >= half) ? ua - (longint'(1) << w) : ua;
    sb = (ub >= half) ? ub - (longint'(1) << w) : ub;
    sh = int'(ub & longint'(w - 1));
    case (op)
      0:  r = ua + ub;
      1:  r = (ua < ub) ? ua : ub;
      2:  r = (sa < sb) ? ua : ub;
      3:  r = (ua + ub + 1) >> 1;
      4:  r = ua & ub;
      5:  r = ua | ub;
      6:  r = ua ^ ub;
      7:  r = (ua == ub) ? mask : 0;
      8:  r = (ua > ub) ? mask : 0;
      9:  r = (sa > sb) ? mask : 0;
      10: r = ua << sh;
      11: r = ua >> sh;
      12: r = sa >>> sh;
      13: r = (ua << sh) | (ua >> (w - sh));
      default: r = 0;
    endcase
    return 32'(r & mask);
  endfunction

  function automatic logic [127:0] ref_vec(int op, logic [1:0] sz, logic [127:0] a, logic [127:0] b);
    int w;
    logic [127:0] acc;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    acc = '0;
    for (int i = 0; i < 128 / w; i++)
      acc |= 128'(ref_lane(op, w, 32'(a >> (i * w)), 32'(b >> (i * w)))) << (i * w);
    return acc;
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(string req, int op, logic [1:0] sz, logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'(op); in_size = sz; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {127'd0, out_valid}, 128'd1);
    check(req, out_result, ref_vec(op, sz, a, b));
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_size = '0; in_a = '0; in_b = '0;
    repeat (2) @(negedge clk);
    check("R9", {127'd0, out_valid}, 128'd0);
    check("R9", out_result, 128'd0);
    rst = 1'b0;
  endtask

  task automatic t_add_wrap();
    run("R2", 0, 2'd0, {16{8'hFF}}, {16{8'h01}});
    check("R2", out_result, 128'd0);
    run("R2", 0, 2'd1, {8{16'hFFFF}}, {8{16'h0001}});
    run("R2", 0, 2'd2, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}});
    run("R2", 0, 2'd0, 128'h80FF_7F01_FFFF_0000_1234_5678_9ABC_DEF0, 128'h80FF_0101_0001_FFFF_EDCB_A987_6543_2110);
  endtask

  task automatic t_size_codes();
    logic [127:0] a = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    logic [127:0] b = 128'hFFFF_0001_8000_7FFF_00FF_FF00_1111_EEEE;
    logic [127:0] r2;
    run("R1", 0, 2'd2, a, b);
    r2 = out_result;
    run("R1", 0, 2'd3, a, b);
    check("R1", out_result, r2);
    run("R1", 0, 2'd1, a, b);
    run("R1", 9, 2'd3, a, b);
  endtask

  task automatic t_min_avg();
    logic [127:0] a = {4{32'h8000_007F}};
    logic [127:0] b = {4{32'h7FFF_FF80}};
    for (int s = 0; s < 3; s++) begin
      run("R3", 1, 2'(s), a, b);
      run("R3", 2, 2'(s), a, b);
      run("R4", 3, 2'(s), {16{8'hFF}}, {16{8'hFF}});
      run("R4", 3, 2'(s), a, b);
    end
  endtask

  task automatic t_logic();
    logic [127:0] a = 128'hF0F0_AAAA_0000_FFFF_1234_5678_9ABC_DEF0;
    logic [127:0] b = 128'hFF00_5555_FFFF_0F0F_0FED_CBA9_8765_4321;
    run("R5", 4, 2'd0, a, b);
    run("R5", 5, 2'd1, a, b);
    run("R5", 6, 2'd2, a, b);
  endtask

  task automatic t_compare();
    logic [127:0] a = 128'h8000_0001_7F7F_0000_FFFF_0001_1234_8000;
    logic [127:0] b = 128'h0000_0001_8080_0000_0001_FFFF_1234_7FFF;
    for (int s = 0; s < 3; s++)
      for (int op = 7; op <= 9; op++)
        run("R6", op, 2'(s), a, b);
  endtask

  task automatic t_shift();
    logic [127:0] a = 128'h8001_C003_F00F_0FF0_8000_0001_DEAD_BEEF;
    logic [127:0] b = 128'hF3E7_2109_FFFF_0A05_1F21_6003_4827_0E13;
    for (int s = 0; s < 3; s++)
      for (int op = 10; op <= 13; op++)
        run("R7", op, 2'(s), a, b);
    run("R7", 13, 2'd0, {16{8'h81}}, {16{8'h08}});
    check("R7", out_result, {16{8'h81}});
  endtask

  task automatic t_reserved_and_hold();
    logic [127:0] held;
    run("R10", 14, 2'd0, {8{16'hABCD}}, {8{16'h1234}});
    check("R10", out_result, 128'd0);
    run("R10", 15, 2'd2, {8{16'hABCD}}, {8{16'h1234}});
    run("R8", 6, 2'd1, {8{16'h1357}}, {8{16'h2468}});
    held = out_result;
    in_op = 4'd0; in_a = '1; in_b = '1;
    @(negedge clk);
    @(negedge clk);
    check("R8", {127'd0, out_valid}, 128'd0);
    check("R8", out_result, held);
  endtask

  task automatic t_mixed();
    for (int n = 0; n < 60; n++) begin
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
      run("R1", n % 14, 2'(n % 4), a, b);
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_add_wrap();
    t_size_codes();
    t_min_avg();
    t_logic();
    t_compare();
    t_shift();
    t_reserved_and_hold();
    t_mixed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule